// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Cycle Controller

This block sits on the system clock and turns single host transactions into timed cycles on an asynchronous, SRAM-compatible memory. The memory side has a 20-bit word address, a 16-bit bidirectional data bus, and active-low select, output-enable, write-enable and two byte-lane strobes. The host offers one request at a time through a request/ready handshake, with an address, write data, a write flag and a two-bit lane mask. Read results come back as a one-cycle valid pulse carrying the data.

Every timing minimum is a parameter counted in system-clock cycles. The controller derives one fixed read length and one fixed write length from them, so each cycle is at least as long as every minimum. A checker keeps each select-low window under an upper bound. A run guard watches for long stretches of back-to-back traffic. When a stretch gets too long, it withholds ready until the memory has seen a quiet gap with select high.

Top module: `psram_ctrl`

## Requirements
- R1: A read drives select low, output enable low and write enable high for its whole active phase. The lane mask picks the strobes: mask bit 0 drives the lower strobe (data bits 7:0) and mask bit 1 drives the upper strobe (bits 15:8). `rsp_valid` pulses for one cycle exactly RD_LEN clock edges after the accepting edge. `rsp_rdata` carries the addressed word, with the bits of any disabled lane forced to zero.
- R2: A write drives select, write enable and the strobes selected by the mask low. Only the enabled byte lanes of the addressed word change.
- R3: Write enable stays low for exactly WR_LEN cycles, where WR_LEN is the largest of the write-pulse, select-to-end, address-to-end, data-setup and cycle minimums. Write enable rises first, and select stays low for one further cycle.
- R4: The read active phase lasts exactly RD_LEN cycles, where RD_LEN is the largest of the cycle, access and output-enable minimums. Output enable and select rise together, at least one cycle before the address may change.
- R5: Address and strobes hold steady while select is low. The address changes only at an edge preceded by a cycle with select, output enable and write enable all high.
- R6: The controller drives the data bus only while write enable is low, and always while it is low. During that time the bus carries the accepted write data.
- R7: No select-low window is longer than MAX_CYC cycles.
- R8: After RUN_LIMIT cycles without a quiet gap of GAP_CYC idle cycles, ready stays low until GAP_CYC idle cycles with select high have passed. With continuous requests, the cycles between such gaps never exceed RUN_LIMIT plus one full write.
- R9: Ready is high only while no cycle is in progress. A request is taken at an edge where `req` and `ready` are both high, and ready is low in the cycle that follows.
- R10: After reset, all memory strobes are high, ready is high and `rsp_valid` is low.
- R11: A transaction with mask 00 still runs a full cycle with both strobes high. Such a write leaves memory unchanged, and such a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request |
| ready | output | 1 | Controller can take a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq | inout | 16 | Memory data bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |

## Verification
The properties assume that the memory drives the bus only while select and output enable are low and write enable is high. They also assume that the host keeps its request fields steady until acceptance. The bench memory model drives each byte lane only under exactly those pin conditions and samples writes only while select and write enable are low. The driver changes request fields only at falling edges, and only once the previous request has been taken. Addresses stay inside the model's 256-word window, so the scoreboard's shadow copy maps one to one.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = 2;
    localparam int unsigned WORD_W = LANE_W * LANES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RD_END,
        ST_WR,
        ST_WR_END
    } seq_state_e;

    // registered pin set for the memory side; all active-low except bus_en
    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic ub_n;
        logic lb_n;
        logic bus_en;
    } pin_ctl_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [WORD_W-1:0] lane_bits(logic [LANES-1:0] lanes);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*LANE_W +: LANE_W] = {LANE_W{lanes[i]}};
        end
        return m;
    endfunction

    function automatic pin_ctl_t pins_for(seq_state_e st, logic [LANES-1:0] lanes);
        pin_ctl_t p;
        p = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, ub_n: 1'b1, lb_n: 1'b1, bus_en: 1'b0};
        case (st)
            ST_RD: begin
                p.cs_n = 1'b0;
                p.oe_n = 1'b0;
                p.ub_n = ~lanes[1];
                p.lb_n = ~lanes[0];
            end
            ST_WR: begin
                p.cs_n   = 1'b0;
                p.we_n   = 1'b0;
                p.ub_n   = ~lanes[1];
                p.lb_n   = ~lanes[0];
                p.bus_en = 1'b1;
            end
            ST_WR_END: begin
                p.cs_n = 1'b0;
                p.ub_n = ~lanes[1];
                p.lb_n = ~lanes[0];
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/psram_seq.sv
module psram_seq
    import psram_pkg::*;
#(
    parameter int unsigned RD_LEN = 14,
    parameter int unsigned WR_LEN = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_wr,
    input  logic [LANES-1:0] lanes,
    output seq_state_e       state_o,
    output logic             rd_done,
    output pin_ctl_t         pins
);

    localparam int unsigned LEN_MAX = max2(RD_LEN, WR_LEN);
    localparam int unsigned CW      = $clog2(LEN_MAX + 1);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rd_done = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = start_wr ? ST_WR : ST_RD;
                    cnt_d   = '0;
                end
            end
            ST_RD: begin
                if (cnt_q == CW'(RD_LEN - 1)) begin
                    state_d = ST_RD_END;
                    rd_done = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_WR: begin
                if (cnt_q == CW'(WR_LEN - 1)) begin
                    state_d = ST_WR_END;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pins    <= pins_for(ST_IDLE, '0);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pins    <= pins_for(state_d, lanes);
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/psram_run_guard.sv
module psram_run_guard #(
    parameter int unsigned RUN_LIMIT = 7800,
    parameter int unsigned GAP_CYC   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic quiet,
    output logic hold
);

    localparam int unsigned RW = $clog2(RUN_LIMIT + 1);
    localparam int unsigned QW = $clog2(GAP_CYC + 1);

    logic [RW-1:0] run_q;
    logic [QW-1:0] quiet_q;
    logic          gap_met;

    assign gap_met = quiet && (quiet_q >= QW'(GAP_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            quiet_q <= '0;
        end else begin
            if (!quiet) begin
                quiet_q <= '0;
            end else if (quiet_q != QW'(GAP_CYC)) begin
                quiet_q <= quiet_q + 1'b1;
            end

            if (gap_met) begin
                run_q <= '0;
            end else if (run_q != RW'(RUN_LIMIT)) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign hold = (run_q == RW'(RUN_LIMIT));

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned T_RC      = 14,
    parameter int unsigned T_ACC     = 14,
    parameter int unsigned T_OEA     = 5,
    parameter int unsigned T_WP      = 10,
    parameter int unsigned T_CW      = 12,
    parameter int unsigned T_AW      = 12,
    parameter int unsigned T_DW      = 4,
    parameter int unsigned MAX_CYC   = 2000,
    parameter int unsigned RUN_LIMIT = 7800,
    parameter int unsigned GAP_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    output logic              ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_lanes,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [15:0]       mem_dq,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n
);

    localparam int unsigned RD_LEN = max2(T_RC, max2(T_ACC, T_OEA));
    localparam int unsigned WR_LEN = max2(max2(T_RC, T_WP), max2(max2(T_CW, T_AW), T_DW));

    seq_state_e        seq_st;
    pin_ctl_t          pins;
    logic              rd_done;
    logic              hold;
    logic              accept;
    logic              quiet;
    logic              drive_bus;
    logic [LANES-1:0]  lanes_q;
    logic [LANES-1:0]  lanes_mux;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] rdata_q;
    logic              rvalid_q;

    assign ready     = (seq_st == ST_IDLE) && !hold;
    assign accept    = req && ready;
    assign quiet     = (seq_st == ST_IDLE) && !accept;
    assign lanes_mux = accept ? req_lanes : lanes_q;

    psram_seq #(
        .RD_LEN (RD_LEN),
        .WR_LEN (WR_LEN)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .start_wr (req_we),
        .lanes    (lanes_mux),
        .state_o  (seq_st),
        .rd_done  (rd_done),
        .pins     (pins)
    );

    psram_run_guard #(
        .RUN_LIMIT (RUN_LIMIT),
        .GAP_CYC   (GAP_CYC)
    ) u_guard (
        .clk   (clk),
        .rst   (rst),
        .quiet (quiet),
        .hold  (hold)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            lanes_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_done;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                lanes_q <= req_lanes;
            end
            if (rd_done) begin
                rdata_q <= mem_dq & lane_bits(lanes_q);
            end
        end
    end

    assign drive_bus = pins.bus_en;
    assign mem_dq    = drive_bus ? wdata_q : 'z;
    assign mem_addr  = addr_q;
    assign mem_cs_n  = pins.cs_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_ub_n  = pins.ub_n;
    assign mem_lb_n  = pins.lb_n;
    assign rsp_valid = rvalid_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned MAX_CYC = 2000
) (
    input logic              clk,
    input logic              rst,
    input logic              ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              drive_bus
);

    localparam int unsigned LW = $clog2(MAX_CYC + 2);

    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || mem_cs_n) begin
            low_run <= '0;
        end else if (low_run != LW'(MAX_CYC + 1)) begin
            low_run <= low_run + 1'b1;
        end
    end

    // R1
    read_pins_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_cs_n && mem_we_n));

    // R3
    we_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> !mem_cs_n);

    // R4
    oe_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (mem_cs_n && $stable(mem_addr)));

    // R5
    addr_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> ($past(mem_cs_n) && $past(mem_oe_n) && $past(mem_we_n)));

    // R6
    bus_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        drive_bus |-> (!mem_we_n && mem_oe_n));

    // R6
    write_drives_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> drive_bus);

    // R7
    cycle_bound_chk: assert property (@(posedge clk) disable iff (rst)
        low_run <= LW'(MAX_CYC));

    // R9
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (mem_cs_n && mem_we_n && mem_oe_n));

    // R10
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && mem_cs_n));

endmodule

bind psram_ctrl psram_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .MAX_CYC (MAX_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .drive_bus (drive_bus)
);

// File: tb/tb_psram_ctrl.sv
`timescale 1ns/1ps
module tb_psram_ctrl;

    localparam int unsigned ADDR_W    = 20;
    localparam int unsigned T_RC      = 14;
    localparam int unsigned T_ACC     = 14;
    localparam int unsigned T_OEA     = 5;
    localparam int unsigned T_WP      = 10;
    localparam int unsigned T_CW      = 12;
    localparam int unsigned T_AW      = 12;
    localparam int unsigned T_DW      = 4;
    localparam int unsigned MAX_CYC   = 2000;
    localparam int unsigned RUN_LIMIT = 300;
    localparam int unsigned GAP_CYC   = 6;

    function automatic int unsigned mx(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    localparam int unsigned EXP_RD = mx(mx(T_RC, T_ACC), T_OEA);
    localparam int unsigned EXP_WR = mx(mx(mx(T_WP, T_CW), mx(T_AW, T_DW)), T_RC);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic              req_we = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [15:0]       req_wdata = '0;
    logic [1:0]        req_lanes = '0;
    logic              ready;
    logic              rsp_valid;
    logic [15:0]       rsp_rdata;
    logic [ADDR_W-1:0] mem_addr;
    wire  [15:0]       mem_dq;
    logic              mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;

    always #2.5 clk = ~clk;

    psram_ctrl #(
        .ADDR_W (ADDR_W), .T_RC (T_RC), .T_ACC (T_ACC), .T_OEA (T_OEA),
        .T_WP (T_WP), .T_CW (T_CW), .T_AW (T_AW), .T_DW (T_DW),
        .MAX_CYC (MAX_CYC), .RUN_LIMIT (RUN_LIMIT), .GAP_CYC (GAP_CYC)
    ) dut (
        .clk (clk), .rst (rst), .req (req), .ready (ready), .req_we (req_we),
        .req_addr (req_addr), .req_wdata (req_wdata), .req_lanes (req_lanes),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .mem_addr (mem_addr),
        .mem_dq (mem_dq), .mem_cs_n (mem_cs_n), .mem_oe_n (mem_oe_n),
        .mem_we_n (mem_we_n), .mem_ub_n (mem_ub_n), .mem_lb_n (mem_lb_n)
    );

    // memory model: 256 words, lanes driven only when read conditions hold
    logic [15:0] model_mem [256];
    logic        rd_en;
    assign rd_en = !mem_cs_n && !mem_oe_n && mem_we_n;
    assign mem_dq[7:0]  = (rd_en && !mem_lb_n) ? model_mem[mem_addr[7:0]][7:0]  : 8'hzz;
    assign mem_dq[15:8] = (rd_en && !mem_ub_n) ? model_mem[mem_addr[7:0]][15:8] : 8'hzz;

    always @(negedge clk) begin
        if (!rst && !mem_cs_n && !mem_we_n) begin
            if (!mem_lb_n) model_mem[mem_addr[7:0]][7:0]  <= mem_dq[7:0];
            if (!mem_ub_n) model_mem[mem_addr[7:0]][15:8] <= mem_dq[15:8];
        end
    end

    int unsigned checks = 0;
    int unsigned errors = 0;
    longint      cyc = 0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req_tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    // scoreboard
    typedef struct {
        logic [15:0] data;
        longint      at;
    } exp_t;
    exp_t        sb_q[$];
    logic [15:0] shadow [256];
    logic [15:0] exp_bus = '0;

    function automatic logic [15:0] lmask(logic [1:0] l);
        return {{8{l[1]}}, {8{l[0]}}};
    endfunction

    task automatic issue(bit wr, logic [7:0] a, logic [15:0] d, logic [1:0] ln);
        req       = 1'b1;
        req_we    = wr;
        req_addr  = ADDR_W'(a);
        req_wdata = d;
        req_lanes = ln;
        while (!ready) @(negedge clk);
        if (wr) begin
            exp_bus   = d;
            shadow[a] = (shadow[a] & ~lmask(ln)) | (d & lmask(ln));
        end else begin
            sb_q.push_back('{data: shadow[a] & lmask(ln), at: cyc + 1 + longint'(EXP_RD)});
        end
        @(negedge clk);
        // R9: ready low in the cycle after acceptance
        check(ready == 1'b0, "R9 ready after accept", ready, 0);
        req = 1'b0;
    endtask

    // monitor: read results
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R1 unexpected rsp_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                // R1 R2 R11 data and latency
                check(rsp_rdata == e.data, "R1/R2/R11 read data", rsp_rdata, e.data);
                check(cyc == e.at, "R1 read latency", cyc, e.at);
            end
        end
    end

    // monitor: pin timing
    int unsigned cs_run = 0, we_run = 0, hi_run = 0;
    int unsigned max_cs = 0, span = 0, max_span = 0, addr_bad = 0;
    bit          saw_we = 1'b0;
    logic [ADDR_W-1:0] addr_prev = '0;
    logic [1:0]        strobe_prev = 2'b11;

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (!mem_cs_n) begin
                cs_run++;
                hi_run = 0;
                if (!mem_we_n) saw_we = 1'b1;
                if (cs_run > 1 && (mem_addr != addr_prev || {mem_ub_n, mem_lb_n} != strobe_prev))
                    addr_bad++;
                if (cs_run > max_cs) max_cs = cs_run;
            end else begin
                if (cs_run > 0) begin
                    if (saw_we)
                        check(cs_run == EXP_WR + 1, "R3 select window of write", cs_run, EXP_WR + 1);
                    else
                        check(cs_run == EXP_RD, "R4 select window of read", cs_run, EXP_RD);
                end
                cs_run = 0;
                saw_we = 1'b0;
                hi_run++;
            end
            if (!mem_we_n) begin
                we_run++;
                // R6: bus carries the write data
                check(mem_dq == exp_bus, "R6 bus data during write", mem_dq, exp_bus);
            end else begin
                if (we_run > 0) check(we_run == EXP_WR, "R3 write pulse", we_run, EXP_WR);
                we_run = 0;
            end
            if (hi_run >= GAP_CYC) span = 0;
            else span++;
            if (span > max_span) max_span = span;
            addr_prev   = mem_addr;
            strobe_prev = {mem_ub_n, mem_lb_n};
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            model_mem[i] = 16'h0000;
            shadow[i]    = 16'h0000;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(mem_cs_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n,
              "R10 strobes after reset",
              {mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 5'h1f);
        check(ready == 1'b1, "R10 ready after reset", ready, 1);
        check(rsp_valid == 1'b0, "R10 rsp_valid after reset", rsp_valid, 0);

        // full-word writes and reads (R1, R2)
        for (int i = 1; i <= 8; i++) issue(1'b1, 8'(i), 16'(16'h1111 * i), 2'b11);
        for (int i = 1; i <= 8; i++) issue(1'b0, 8'(i), 16'h0, 2'b11);

        // byte lanes (R2): lower then upper
        issue(1'b1, 8'd3, 16'hAB55, 2'b01);
        issue(1'b1, 8'd4, 16'hC0DE, 2'b10);
        issue(1'b0, 8'd3, 16'h0, 2'b11);
        issue(1'b0, 8'd4, 16'h0, 2'b11);
        // partial reads (R1): disabled lane returns zero
        issue(1'b0, 8'd7, 16'h0, 2'b01);
        issue(1'b0, 8'd7, 16'h0, 2'b10);

        // mask 00 (R11)
        issue(1'b1, 8'd5, 16'hFFFF, 2'b00);
        issue(1'b0, 8'd5, 16'h0, 2'b11);
        issue(1'b0, 8'd6, 16'h0, 2'b00);

        // long back-to-back stream to drive the run guard (R8)
        for (int i = 0; i < 60; i++) begin
            issue(i[0], 8'(8'h40 + (i % 16)), 16'(16'h9000 + i * 7), 2'((i % 3) + 1));
        end

        repeat (EXP_RD + 6) @(negedge clk);
        check(sb_q.size() == 0, "R1 all reads returned", sb_q.size(), 0);
        check(addr_bad == 0, "R5 address/strobes steady while selected", addr_bad, 0);
        check(max_cs <= MAX_CYC, "R7 select window bound", max_cs, MAX_CYC);
        check(max_span <= RUN_LIMIT + EXP_WR + 4, "R8 run between gaps", max_span,
              RUN_LIMIT + EXP_WR + 4);
        check(max_span >= RUN_LIMIT, "R8 stream reached the guard", max_span, RUN_LIMIT);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule